// File: doc/BRIEF.md
# Pairwise Hyperplane Vote Classifier

This block sorts an input feature vector into one of K classes using a one-against-one scheme in which no arithmetic is evaluated. Every pair of classes has its own small ternary lookup table, so there are K(K-1)/2 tables. Each table is keyed by all features at once and answers with a single bit that says on which side of that pair's separating surface the input lies. A tally stage gives each bit to one class of its pair, counts the votes each class received, and the class with the most votes is reported.

Before the lookup, the features are merged into one key by interleaving their bits, highest bit position first. A ternary entry that masks off low key bits therefore covers a box-shaped range across all features. Software fills the tables through a single write port: an entry holds a key value, a care mask, a vote bit and a live flag, and each table also has a vote bit that it returns on a miss. The classifier accepts one feature vector per cycle and returns each result after a fixed three-cycle latency.

Top module: `hpv_classifier`

## Requirements
- R1: Pairs are numbered in the order (0,1),(0,2),...,(0,K-1),(1,2),...,(K-2,K-1), and wr_table selects a pair by this number. A vote bit of 1 from pair (i,j), i<j, credits class i. A vote bit of 0 credits class j.
- R2: Key bit j*NUM_FEAT+f is bit j of feature f, and feature f occupies in_feat[f*FEAT_W +: FEAT_W]. With NUM_FEAT=2 and FEAT_W=8, key bit 14 is in_feat bit 7.
- R3: An entry matches when it is live and (key & mask) equals (value & mask). A mask bit of 1 means the key bit is compared and 0 means it is ignored.
- R4: When several entries of one table match, the entry with the lowest index supplies the vote.
- R5: When no entry of a table matches, the table returns its default vote bit. wr_en with wr_dflt=1 sets that bit of table wr_table to wr_vote.
- R6: The output class has the highest vote count. A tie goes to the lowest class index. The counts always sum to K(K-1)/2.
- R7: out_valid is high exactly three cycles after each cycle with in_valid high, and at no other time. Consecutive inputs are accepted on consecutive cycles.
- R8: An entry write (wr_en=1, wr_dflt=0) replaces slot wr_index of table wr_table and affects every lookup presented on a later cycle. Writing with wr_live=0 removes the entry.
- R9: After reset, out_valid is low, every entry is removed, and every default vote is 0. An input then yields class K-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Feature vector strobe |
| in_feat | input | NUM_FEAT*FEAT_W | Packed feature vector |
| wr_en | input | 1 | Table write strobe |
| wr_dflt | input | 1 | 1: write the miss vote, 0: write an entry |
| wr_table | input | TBL_W | Pair number of the target table |
| wr_index | input | IDX_W | Entry slot |
| wr_value | input | KEY_W | Entry key value (interleaved order) |
| wr_mask | input | KEY_W | Entry care mask |
| wr_vote | input | 1 | Vote bit of the entry or of the miss default |
| wr_live | input | 1 | Entry live flag |
| out_valid | output | 1 | Result strobe |
| out_class | output | CLS_W | Winning class index |

## Verification
Some properties are checked on every cycle: the three-cycle correspondence between in_valid and out_valid, the sum of the class counts equal to the pair count, the winner holding the maximum count while beating every lower index strictly, and the class staying in range. Other behaviour can only be shown by the bench's scenarios: the bit interleaving of the key, ternary masking, priority between entries, the miss default, the meaning of each vote bit, the write-to-lookup ordering and entry removal. The bench checks these by comparing the results against a separate model of the tables.

// File: rtl/hpv_pkg.sv
package hpv_pkg;

  function automatic int pair_count(input int k);
    return (k * (k - 1)) / 2;
  endfunction

  // lower-numbered class of pair p
  function automatic int pair_lo(input int k, input int p);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int i = 0; i < k; i++)
      for (int j = i + 1; j < k; j++) begin
        if (n == p) r = i;
        n++;
      end
    return r;
  endfunction

  // higher-numbered class of pair p
  function automatic int pair_hi(input int k, input int p);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int i = 0; i < k; i++)
      for (int j = i + 1; j < k; j++) begin
        if (n == p) r = j;
        n++;
      end
    return r;
  endfunction

endpackage

// File: rtl/hpv_side_table.sv
module hpv_side_table #(
  parameter int KEY_W = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_dflt,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_vote,
  input  logic             wr_live,
  input  logic [KEY_W-1:0] key,
  output logic             vote
);

  logic [DEPTH-1:0] live_q, live_d;
  logic [DEPTH-1:0] slot_we;
  logic [DEPTH-1:0] vote_q;
  logic [KEY_W-1:0] val_q  [DEPTH];
  logic [KEY_W-1:0] mask_q [DEPTH];
  logic             dflt_q, dflt_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      slot_we[i] = sel && !wr_dflt && (wr_index == IDX_W'(i));
    live_d = live_q;
    for (int i = 0; i < DEPTH; i++)
      if (slot_we[i]) live_d[i] = wr_live;
    dflt_d = (sel && wr_dflt) ? wr_vote : dflt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      dflt_q <= 1'b0;
    end else begin
      live_q <= live_d;
      dflt_q <= dflt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_we[i]) begin
        val_q[i]  <= wr_value;
        mask_q[i] <= wr_mask;
        vote_q[i] <= wr_vote;
      end
    end
  end

  // descending scan: the lowest matching index is applied last
  always_comb begin
    vote = dflt_q;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (live_q[i] && ((key & mask_q[i]) == (val_q[i] & mask_q[i])))
        vote = vote_q[i];
  end

endmodule

// File: rtl/hpv_tally.sv
module hpv_tally #(
  parameter int NUM_CLASSES = 4,
  localparam int NUM_PAIRS = hpv_pkg::pair_count(NUM_CLASSES),
  localparam int CNT_W = $clog2(NUM_CLASSES)
) (
  input  logic [NUM_PAIRS-1:0]         votes,
  output logic [NUM_CLASSES*CNT_W-1:0] counts
);

  logic [NUM_PAIRS*NUM_CLASSES-1:0] credit;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int LO = hpv_pkg::pair_lo(NUM_CLASSES, p);
    localparam int HI = hpv_pkg::pair_hi(NUM_CLASSES, p);
    assign credit[p*NUM_CLASSES +: NUM_CLASSES] =
      votes[p] ? (NUM_CLASSES'(1) << LO) : (NUM_CLASSES'(1) << HI);
  end

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      counts[c*CNT_W +: CNT_W] = '0;
      for (int p = 0; p < NUM_PAIRS; p++)
        counts[c*CNT_W +: CNT_W] = counts[c*CNT_W +: CNT_W]
                                   + CNT_W'(credit[p*NUM_CLASSES + c]);
    end
  end

endmodule

// File: rtl/hpv_argmax.sv
module hpv_argmax #(
  parameter int NUM_CLASSES = 4,
  localparam int CNT_W = $clog2(NUM_CLASSES),
  localparam int CLS_W = $clog2(NUM_CLASSES)
) (
  input  logic [NUM_CLASSES*CNT_W-1:0] counts,
  output logic [CLS_W-1:0]             winner
);

  logic [CNT_W-1:0] best;

  // strict compare keeps the lower index on a tie
  always_comb begin
    winner = '0;
    best   = counts[0 +: CNT_W];
    for (int c = 1; c < NUM_CLASSES; c++)
      if (counts[c*CNT_W +: CNT_W] > best) begin
        best   = counts[c*CNT_W +: CNT_W];
        winner = CLS_W'(c);
      end
  end

endmodule

// File: rtl/hpv_classifier.sv
module hpv_classifier #(
  parameter int NUM_CLASSES = 4,
  parameter int NUM_FEAT    = 2,
  parameter int FEAT_W      = 8,
  parameter int DEPTH       = 8,
  localparam int NUM_PAIRS  = hpv_pkg::pair_count(NUM_CLASSES),
  localparam int KEY_W      = NUM_FEAT * FEAT_W,
  localparam int TBL_W      = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W      = $clog2(NUM_CLASSES),
  localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_feat,
  input  logic             wr_en,
  input  logic             wr_dflt,
  input  logic [TBL_W-1:0] wr_table,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_vote,
  input  logic             wr_live,
  output logic             out_valid,
  output logic [CLS_W-1:0] out_class
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // bit-interleaved key, highest bit positions on top
  logic [KEY_W-1:0] key;
  for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
    for (genvar j = 0; j < FEAT_W; j++) begin : g_bit
      assign key[j*NUM_FEAT + f] = in_feat[f*FEAT_W + j];
    end
  end

  logic [NUM_PAIRS-1:0] vote_c;
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_tbl
    hpv_side_table #(.KEY_W(KEY_W), .DEPTH(DEPTH)) tbl_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .sel      (wr_en && (wr_table == TBL_W'(p))),
      .wr_dflt  (wr_dflt),
      .wr_index (wr_index),
      .wr_value (wr_value),
      .wr_mask  (wr_mask),
      .wr_vote  (wr_vote),
      .wr_live  (wr_live),
      .key      (key),
      .vote     (vote_c[p])
    );
  end

  logic                         s1_valid_q, s2_valid_q;
  logic [NUM_PAIRS-1:0]         s1_votes_q;
  logic [NUM_CLASSES*CNT_W-1:0] counts_c, s2_counts_q;
  logic [CLS_W-1:0]             winner_c;

  hpv_tally #(.NUM_CLASSES(NUM_CLASSES)) tally_i (
    .votes  (s1_votes_q),
    .counts (counts_c)
  );

  hpv_argmax #(.NUM_CLASSES(NUM_CLASSES)) argmax_i (
    .counts (s2_counts_q),
    .winner (winner_c)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      s1_valid_q <= in_valid;
      s2_valid_q <= s1_valid_q;
      out_valid  <= s2_valid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid)   s1_votes_q  <= vote_c;
    if (s1_valid_q) s2_counts_q <= counts_c;
    if (s2_valid_q) out_class   <= winner_c;
  end

endmodule

// File: rtl/hpv_classifier_chk.sv
module hpv_classifier_chk #(
  parameter int NUM_CLASSES = 4,
  localparam int NUM_PAIRS = hpv_pkg::pair_count(NUM_CLASSES),
  localparam int CNT_W = $clog2(NUM_CLASSES),
  localparam int CLS_W = $clog2(NUM_CLASSES)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         s2_valid,
  input logic [NUM_CLASSES*CNT_W-1:0] s2_counts,
  input logic                         out_valid,
  input logic [CLS_W-1:0]             out_class
);

  int                           sum_c;
  logic [NUM_CLASSES*CNT_W-1:0] held_q;
  logic                         win_ok;

  always_comb begin
    sum_c = 0;
    for (int c = 0; c < NUM_CLASSES; c++)
      sum_c = sum_c + int'(s2_counts[c*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) held_q <= s2_counts;

  always_comb begin
    win_ok = 1'b1;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (c < int'(out_class) &&
          held_q[c*CNT_W +: CNT_W] >= held_q[int'(out_class)*CNT_W +: CNT_W])
        win_ok = 1'b0;
      if (held_q[c*CNT_W +: CNT_W] > held_q[int'(out_class)*CNT_W +: CNT_W])
        win_ok = 1'b0;
    end
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  a_r6_vote_total: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (sum_c == NUM_PAIRS));

  a_r6_argmax_tie: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> win_ok);

  a_r1_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_class) < NUM_CLASSES));

endmodule

bind hpv_classifier hpv_classifier_chk #(.NUM_CLASSES(NUM_CLASSES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .s2_valid  (s2_valid_q),
  .s2_counts (s2_counts_q),
  .out_valid (out_valid),
  .out_class (out_class)
);

// File: tb/hpv_classifier_tb.sv
module hpv_classifier_tb_top;

  localparam int K  = 4;
  localparam int NP = 6;
  localparam int D  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_feat;
  logic        wr_en, wr_dflt, wr_vote, wr_live;
  logic [2:0]  wr_table, wr_index;
  logic [15:0] wr_value, wr_mask;
  logic        out_valid;
  logic [1:0]  out_class;

  always #2.5 clk = ~clk;

  hpv_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_feat(in_feat),
    .wr_en(wr_en), .wr_dflt(wr_dflt), .wr_table(wr_table), .wr_index(wr_index),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_vote(wr_vote), .wr_live(wr_live),
    .out_valid(out_valid), .out_class(out_class)
  );

  typedef struct { int cls; int due; string tag; } exp_t;
  exp_t sb[$];

  int  errors = 0, checks = 0, cyc = 0;
  bit  armed = 0, ended = 0;
  int  plo[NP], phi[NP];
  logic [15:0] mv[NP][D], mm[NP][D];
  bit  mvote[NP][D], mlive[NP][D], mdflt[NP];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_class(input logic [15:0] feat);
    logic [15:0] key;
    int cnt[K];
    int best;
    bit v;
    for (int f = 0; f < 2; f++)
      for (int j = 0; j < 8; j++) key[j*2 + f] = feat[f*8 + j];
    for (int c = 0; c < K; c++) cnt[c] = 0;
    for (int p = 0; p < NP; p++) begin
      v = mdflt[p];
      for (int e = D - 1; e >= 0; e--)
        if (mlive[p][e] && ((key & mm[p][e]) == (mv[p][e] & mm[p][e]))) v = mvote[p][e];
      if (v) cnt[plo[p]]++; else cnt[phi[p]]++;
    end
    best = 0;
    for (int c = 1; c < K; c++) if (cnt[c] > cnt[best]) best = c;
    return best;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_entry(input int t, input int e, input logic [15:0] v,
                           input logic [15:0] m, input bit vt, input bit lv);
    wr_en = 1; wr_dflt = 0; wr_table = 3'(t); wr_index = 3'(e);
    wr_value = v; wr_mask = m; wr_vote = vt; wr_live = lv;
    mv[t][e] = v; mm[t][e] = m; mvote[t][e] = vt; mlive[t][e] = lv;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put_dflt(input int t, input bit vt);
    wr_en = 1; wr_dflt = 1; wr_table = 3'(t); wr_vote = vt;
    mdflt[t] = vt;
    @(negedge clk);
    wr_en = 0; wr_dflt = 0;
  endtask

  task automatic classify(input logic [15:0] feat, input string tag);
    exp_t x;
    x.cls = ref_class(feat); x.due = cyc + 3; x.tag = tag;
    sb.push_back(x);
    in_valid = 1; in_feat = feat;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (armed && out_valid) begin
      if (sb.size() == 0) check("R7 spurious out_valid", 1, 0);
      else begin
        exp_t x;
        x = sb.pop_front();
        check({x.tag, " class"}, int'(out_class), x.cls);
        check("R7 latency", cyc, x.due);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    n = 0;
    for (int i = 0; i < K; i++)
      for (int j = i + 1; j < K; j++) begin plo[n] = i; phi[n] = j; n++; end
    for (int p = 0; p < NP; p++) begin
      mdflt[p] = 0;
      for (int e = 0; e < D; e++) begin mlive[p][e] = 0; mv[p][e] = 0; mm[p][e] = 0; mvote[p][e] = 0; end
    end
    rst_n = 0; in_valid = 0; in_feat = 0; wr_en = 0; wr_dflt = 0; wr_table = 0;
    wr_index = 0; wr_value = 0; wr_mask = 0; wr_vote = 0; wr_live = 0;
    repeat (4) @(negedge clk);
    check("R9 out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    armed = 1;

    // R9: empty tables, default 0 everywhere -> class 3
    classify(16'h1234, "R9");
    drain();
    // R5: miss default of pair (2,3) -> class 2 wins
    put_dflt(5, 1);
    classify(16'h0000, "R5");
    // R1: pairs (0,x) all vote 1 -> class 0
    put_dflt(0, 1); put_dflt(1, 1); put_dflt(2, 1);
    classify(16'h00ff, "R1");
    // R6: three-way tie of classes 0,1,3 -> class 0
    put_dflt(0, 0); put_dflt(1, 1); put_dflt(2, 1);
    put_dflt(3, 1); put_dflt(4, 0); put_dflt(5, 0);
    classify(16'h0000, "R6");
    // R6: tie of classes 1,2,3 -> class 1
    put_dflt(1, 0); put_dflt(2, 0); put_dflt(5, 1);
    classify(16'h0000, "R6");
    drain();
    for (int p = 0; p < NP; p++) put_dflt(p, 0);

    // R2: key bit 14 is in_feat bit 7
    put_entry(5, 0, 16'h4000, 16'h4000, 1, 1);
    classify(16'h0080, "R2 hit");
    classify(16'h4000, "R2 miss");
    // R3: two cared bits, rest ignored
    put_entry(5, 0, 16'hC000, 16'hC000, 1, 1);
    classify(16'h8080, "R3 hit");
    classify(16'h0080, "R3 miss");
    classify(16'h80ff, "R3 dontcare");
    // R4: catch-all at slot 0 beats specific entry at slot 1
    put_dflt(5, 1);
    put_entry(5, 1, 16'hC000, 16'hC000, 1, 1);
    put_entry(5, 0, 16'h0000, 16'h0000, 0, 1);
    classify(16'h8080, "R4 lowest index");
    // R8: remove slot 0 -> slot 1 decides again on the very next cycle
    put_entry(5, 0, 16'h0000, 16'h0000, 0, 0);
    classify(16'h8080, "R8 removed");
    classify(16'h0001, "R8 miss default");
    drain();

    // R7: randomized tables and back-to-back stream
    for (int p = 0; p < NP; p++) begin
      put_dflt(p, 1'($urandom));
      for (int e = 0; e < D; e++)
        put_entry(p, e, 16'($urandom), 16'($urandom) & 16'hF0F0,
                  1'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 200; i++) begin
      classify(16'($urandom), "R7 stream");
      if ($urandom % 4 == 0) @(negedge clk);
    end
    drain();
    check("R7 scoreboard empty", sb.size(), 0);
    finish_run();
  end

endmodule